// File: doc/BRIEF.md
# Two-Phase Dithered PWM Generator

This block produces a pulse-width-modulated pin value from an 8-bit duty setting. One full period lasts 256 clocks and is split into two halves of 128 clocks. The upper seven bits of the duty setting give a base high time that both halves share. The lowest bit lends one extra high clock to the first half only. The waveform therefore repeats at twice the rate a plain 256-step counter would give, and the average duty still has full 8-bit resolution.

A written duty value waits in a holding register. It moves into the working register only when a period ends, so a period never mixes two settings. Two port-control inputs gate the pin. A data bit of 0 forces the pin value low. A direction bit of 1 makes the pin an input: the enable indication for the pad drops and the block drives nothing.

Top module: `dpwm7p1`

## Requirements
- R1: A free-running position counter steps through 0 to 255 and then wraps to 0. Positions 0 to 127 form half 0 and positions 128 to 255 form half 1. The last position of a period (255) always has a low pin value.
- R2: The working duty value W splits into a base B = W[7:1] and a dither bit D = W[0]. Half 0 is high for B+D clocks out of 128, and half 1 is high for B clocks out of 128.
- R3: Within each half the pin is high from the first position of the half and goes low once the position inside the half reaches that half's high count. With a nonzero working value, the first clock of half 0 is high.
- R4: A write updates the holding register. The holding value enters the working register at the clock edge that ends position 255. A write made in that same cycle is the value that enters. A write made earlier in a period does not change the period in progress.
- R5: When `port_data` is 0, `pwm_pin` is 0.
- R6: When `port_dir` is 1, `pwm_oe` is 0 and `pwm_pin` is 0. When `port_dir` is 0, `pwm_oe` is 1.
- R7: A working value of 0 keeps the pin low for the whole period. A value of 255 gives 128 high clocks in half 0 and 127 in half 1.
- R8: A synchronous reset clears the counter, the holding register and the working register to 0. The first period after reset is therefore all low.
- R9: Working values 100, 101, 102 and 103 give (50,50), (51,50), (51,51) and (52,51) high clocks in (half 0, half 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| duty_wr | input | 1 | Write strobe for the duty holding register |
| duty_wdata | input | 8 | Duty value to write |
| port_data | input | 1 | Port data bit; 1 lets the waveform reach the pin |
| port_dir | input | 1 | Port direction bit; 1 makes the pin an input |
| pwm_pin | output | 1 | Pin output value |
| pwm_oe | output | 1 | Output enable for the pad |

## Verification
Two functions can act in the same clock: a duty write and the end-of-period reload. The bench waits until its model reaches position 255, writes a new value in exactly that cycle, and then counts the high clocks of the next period against the value it just wrote. It also writes in the middle of a period while it counts, and checks that the count still matches the old value. A behavioural model checks the pin on every clock, and per-half high counts are checked for every duty value from 0 to 255.

// File: rtl/dpwm7p1.sv
module dpwm7p1 #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          duty_wr,
  input  logic [DW-1:0] duty_wdata,
  input  logic          port_data,
  input  logic          port_dir,
  output logic          pwm_pin,
  output logic          pwm_oe
);
  localparam int PW = DW - 1;
  localparam logic [DW-1:0] LAST = '1;

  logic [DW-1:0] cnt;
  logic [DW-1:0] hold_q;
  logic [DW-1:0] work_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      hold_q <= '0;
      work_q <= '0;
    end else begin
      cnt <= cnt + 1'b1;
      if (duty_wr) hold_q <= duty_wdata;
      if (cnt == LAST) work_q <= duty_wr ? duty_wdata : hold_q;
    end
  end

  wire          half  = cnt[DW-1];
  wire [PW-1:0] phase = cnt[PW-1:0];

  wire [DW-1:0] thresh = {1'b0, work_q[DW-1:1]}
                       + {{PW{1'b0}}, work_q[0] & ~half};
  wire          raw    = {1'b0, phase} < thresh;

  assign pwm_oe  = ~port_dir;
  assign pwm_pin = raw & port_data & ~port_dir;
endmodule

module dpwm7p1_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [DW-1:0] cnt,
  input logic [DW-1:0] work_q,
  input logic          port_data,
  input logic          port_dir,
  input logic          pwm_pin,
  input logic          pwm_oe
);
  localparam logic [DW-1:0] LAST = '1;

  p_period_end_low_r1: assert property (@(posedge clk) disable iff (rst)
    (cnt == LAST) |-> !pwm_pin);

  p_first_high_r3: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0 && work_q != '0 && port_data && !port_dir) |-> pwm_pin);

  p_work_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (cnt != LAST) |=> $stable(work_q));

  p_data_gate_r5: assert property (@(posedge clk) disable iff (rst)
    !port_data |-> !pwm_pin);

  p_input_mode_r6: assert property (@(posedge clk) disable iff (rst)
    port_dir |-> (!pwm_oe && !pwm_pin));

  p_zero_low_r7: assert property (@(posedge clk) disable iff (rst)
    (work_q == '0) |-> !pwm_pin);

  p_reset_clear_r8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cnt == '0 && work_q == '0));
endmodule

bind dpwm7p1 dpwm7p1_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .cnt(cnt), .work_q(work_q),
  .port_data(port_data), .port_dir(port_dir),
  .pwm_pin(pwm_pin), .pwm_oe(pwm_oe)
);

// File: tb/sim_dpwm7p1.sv
module sim_dpwm7p1;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic duty_wr = 1'b0;
  logic [7:0] duty_wdata = 8'd0;
  logic port_data = 1'b1;
  logic port_dir = 1'b0;
  logic pwm_pin, pwm_oe;

  dpwm7p1 u0 (
    .clk(clk), .rst(rst), .duty_wr(duty_wr), .duty_wdata(duty_wdata),
    .port_data(port_data), .port_dir(port_dir),
    .pwm_pin(pwm_pin), .pwm_oe(pwm_oe)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0;
  int m_pos = 0, m_hold = 0, m_work = 0;
  logic last_pin;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL R1 watchdog: actual cycles %0d expected <= 200000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int model_pin();
    int half, ph, base, dith, hi;
    half = m_pos / 128;
    ph   = m_pos % 128;
    base = m_work / 2;
    dith = m_work % 2;
    hi   = base + ((half < dith) ? 1 : 0);
    if (port_dir || !port_data) return 0;
    return (ph < hi) ? 1 : 0;
  endfunction

  task automatic step(input bit wr, input int d);
    duty_wr = wr;
    duty_wdata = d[7:0];
    #1;
    last_pin = pwm_pin;
    chk("R3 per-clock pin", int'(pwm_pin), model_pin());
    chk("R6 per-clock oe", int'(pwm_oe), port_dir ? 0 : 1);
    @(posedge clk);
    if (rst) begin
      m_pos = 0; m_hold = 0; m_work = 0;
    end else begin
      if (m_pos == 255) m_work = wr ? d : m_hold;
      if (wr) m_hold = d;
      m_pos = (m_pos + 1) % 256;
    end
    @(negedge clk);
    duty_wr = 1'b0;
  endtask

  task automatic count_period(input int wr_at, input int wr_val,
                              output int h0, output int h1);
    h0 = 0; h1 = 0;
    for (int p = 0; p < 256; p++) begin
      step(p == wr_at, wr_val);
      if (last_pin) begin
        if (p < 128) h0++; else h1++;
      end
    end
  endtask

  initial begin
    int h0, h1;
    @(negedge clk);
    rst = 1'b1;
    step(0, 0);
    step(1, 77);
    #1;
    chk("R8 pin low in reset", int'(pwm_pin), 0);
    chk("R6 oe high with dir 0", int'(pwm_oe), 1);
    rst = 1'b0;

    // R8: first period after reset is all low; sweep value 0 starts here
    for (int v = 0; v < 256; v++) begin
      count_period(10, (v + 1) % 256, h0, h1);
      chk($sformatf("R2 half0 v=%0d", v), h0, v / 2 + v % 2);
      chk($sformatf("R2 half1 v=%0d", v), h1, v / 2);
      if (v == 0) begin
        chk("R8 R7 zero period half0", h0, 0);
        chk("R7 zero period half1", h1, 0);
      end
      if (v == 255) begin
        chk("R7 full half0", h0, 128);
        chk("R7 full half1", h1, 127);
      end
      if (v == 100) chk("R9 v100", h0 * 1000 + h1, 50050);
      if (v == 101) chk("R9 v101", h0 * 1000 + h1, 51050);
      if (v == 102) chk("R9 v102", h0 * 1000 + h1, 51051);
      if (v == 103) chk("R9 v103", h0 * 1000 + h1, 52051);
      if (v == 50) chk("R4 mid-period write ignored", h0 + h1, 50);
    end

    // R4: write in the last clock of a period, while reload happens
    count_period(-1, 0, h0, h1);
    while (m_pos != 255) step(0, 0);
    step(1, 9);
    count_period(-1, 0, h0, h1);
    chk("R4 same-cycle write half0", h0, 5);
    chk("R4 same-cycle write half1", h1, 4);

    // R5: data bit low forces pin low
    while (m_pos != 0) step(0, 0);
    port_data = 1'b0;
    count_period(-1, 0, h0, h1);
    chk("R5 gated period highs", h0 + h1, 0);
    port_data = 1'b1;

    // R6: input mode
    port_dir = 1'b1;
    count_period(-1, 0, h0, h1);
    chk("R6 input mode highs", h0 + h1, 0);
    #1;
    chk("R6 oe low in input mode", int'(pwm_oe), 0);
    port_dir = 1'b0;
    count_period(-1, 0, h0, h1);
    chk("R6 restored half0", h0, 5);

    // R1: high count repeats in next period without new write
    count_period(-1, 0, h0, h1);
    chk("R1 repeat half1", h1, 4);

    // R8: mid-run reset clears everything
    step(0, 0);
    rst = 1'b1;
    step(0, 0);
    rst = 1'b0;
    count_period(-1, 0, h0, h1);
    chk("R8 after reset period", h0 + h1, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule